// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Port

This block sends and receives ten-bit asynchronous character frames on a pair of serial lines. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. An external baud source supplies a one-cycle pulse on every overflow. The block divides this pulse by two when halving is selected, and uses the result as a sampling tick at sixteen times the bit rate.

Software reaches the block through a two-location register port. Writing the data location starts a transmission. Reading the data location returns the last accepted received character. The control location holds the receive enable, the address-filter enable and the halving select. It also shows the received stop bit and the two sticky flags: RI for a received character and TI for a sent character.

On the receive side, the phase counter re-aligns on every falling edge of the line. Each bit is decided by a two-of-three vote on three consecutive ticks near the middle of the bit. A frame whose start bit decides high is abandoned. A completed frame reaches the buffer only when the previous character has been taken and the filter rule lets it through.

Top module: `uart_duplex_port`

## Requirements
- R1: A transmitted frame on `txd` is 0, then data bits 0 to 7 in order, then 1, each held for one bit period. `txd` rests at 1 when no frame is in progress.
- R2: A bit period is 16 baud pulses when the halving bit (control bit 2) is 0, and 32 baud pulses when it is 1. The transmit phase counter runs freely from reset, so bit boundaries fall on baud pulse counts that are multiples of the period.
- R3: A write to location 0 (`reg_addr`=0) never changes `txd` in the cycle of the write. The start bit appears at the first bit boundary after the write.
- R4: TI (control bit 5) is set on the tenth bit boundary after the write, which is the edge that drives the stop bit. TI is still 0 one baud pulse earlier.
- R5: Frames arriving while the receive-enable bit (control bit 0) is 0 change neither the receive buffer nor RI.
- R6: Each received bit takes the majority of the line at tick states 8, 9 and 10 after the edge-aligned start. A line inverted for a single tick inside a bit does not change the received byte.
- R7: A falling edge whose start bit decides 1 is dropped without setting RI, and the receiver goes back to hunting for the next falling edge.
- R8: At the middle of the stop bit, three things are loaded only if RI is 0 and either the filter bit (control bit 1) is 0 or the stop bit is 1. The received byte goes to location 0 on read, the stop bit goes to control bit 3, and RI (control bit 4) is set. Otherwise the buffer and the flags keep their values.
- R9: Hardware never clears RI or TI. A write to location 1 clears RI when bit 4 is 0 and clears TI when bit 5 is 0. Writing 1 to either bit leaves it unchanged.
- R10: `irq` is 1 exactly when RI or TI is 1.
- R11: After reset, `txd`=1, `irq`=0, location 1 reads 0 and location 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per baud-source overflow |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the data buffer, 1 selects control/status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the location selected by `reg_addr` |
| rxd | input | 1 | Serial receive line, asynchronous, idles high |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Request, set while RI or TI is pending |

## Verification
The checker assumes that `reg_wr` and `reg_addr` are valid at every clock edge outside reset. It also assumes that `baud_tick` is a single-cycle pulse. The stimulus produces the baud pulse from a free-running phase counter, one pulse in every four clocks. Transmit writes are issued only in cycles without a pulse, so a write never coincides with a bit boundary and the expected start boundary is unambiguous. Serial input is driven on falling clock edges, aligned just after a pulse. Each glitch is exactly one tick long, so it corrupts at most one of the three votes for a bit.

// File: rtl/uart_port_pkg.sv
package uart_port_pkg;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int unsigned CB_RX_EN  = 0;
  localparam int unsigned CB_FILTER = 1;
  localparam int unsigned CB_HALF   = 2;
  localparam int unsigned CB_STOP   = 3;
  localparam int unsigned CB_RI     = 4;
  localparam int unsigned CB_TI     = 5;

  typedef enum logic {RX_HUNT, RX_RECV} rx_state_e;

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic half_rate,
  output logic s16_tick,
  output logic tx_roll
);
  localparam int unsigned DIV_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic             tgl_q, tgl_n;
  logic [DIV_W-1:0] div_q, div_n;

  always_comb begin
    tgl_n    = tgl_q;
    div_n    = div_q;
    s16_tick = baud_tick & (~half_rate | tgl_q);
    tx_roll  = s16_tick && (div_q == DIV_W'(OVS - 1));
    if (baud_tick) tgl_n = ~tgl_q;
    if (s16_tick) div_n = (div_q == DIV_W'(OVS - 1)) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
      div_q <= '0;
    end else begin
      tgl_q <= tgl_n;
      div_q <= div_n;
    end
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              roll,
  output logic              txd,
  output logic              frame_done
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q, frame_n;
  logic [CNT_W-1:0]   left_q, left_n;
  logic               txd_q, txd_n;

  always_comb begin
    frame_n    = frame_q;
    left_n     = left_q;
    txd_n      = txd_q;
    frame_done = 1'b0;
    if (load) begin
      frame_n = {1'b1, load_data, 1'b0};
      left_n  = CNT_W'(FRAME_W);
    end else if (roll && (left_q != '0)) begin
      txd_n      = frame_q[0];
      frame_n    = {1'b1, frame_q[FRAME_W-1:1]};
      left_n     = left_q - 1'b1;
      frame_done = (left_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      txd_q   <= 1'b1;
    end else begin
      frame_q <= frame_n;
      left_q  <= left_n;
      txd_q   <= txd_n;
    end
  end

  assign txd = txd_q;
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              s16_tick,
  input  logic              rxd_sync,
  output logic              frame_done,
  output logic              frame_stop,
  output logic [DATA_W-1:0] frame_data
);
  localparam int unsigned DIV_W  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned BIT_W  = $clog2(DATA_W + 2);
  localparam int unsigned SMP_A  = OVS / 2;
  localparam int unsigned SMP_B  = OVS / 2 + 1;
  localparam int unsigned SMP_C  = OVS / 2 + 2;

  rx_state_e         state_q, state_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [1:0]        smp_q, smp_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              last_q, last_n;
  logic              vote;

  assign vote = (smp_q[0] & smp_q[1]) | (smp_q[0] & rxd_sync) | (smp_q[1] & rxd_sync);

  always_comb begin
    state_n    = state_q;
    div_n      = div_q;
    bit_n      = bit_q;
    smp_n      = smp_q;
    sh_n       = sh_q;
    last_n     = last_q;
    frame_done = 1'b0;
    if (s16_tick) last_n = rxd_sync;
    if (!enable) begin
      state_n = RX_HUNT;
    end else if (s16_tick) begin
      case (state_q)
        RX_HUNT: begin
          if (last_q && !rxd_sync) begin
            state_n = RX_RECV;
            div_n   = '0;
            bit_n   = '0;
          end
        end
        default: begin
          div_n = (div_q == DIV_W'(OVS - 1)) ? '0 : div_q + 1'b1;
          if (div_n == DIV_W'(SMP_A)) smp_n[0] = rxd_sync;
          if (div_n == DIV_W'(SMP_B)) smp_n[1] = rxd_sync;
          if (div_n == DIV_W'(SMP_C)) begin
            bit_n = bit_q + 1'b1;
            if (bit_q == '0) begin
              if (vote) state_n = RX_HUNT;
            end else if (bit_q <= BIT_W'(DATA_W)) begin
              sh_n = {vote, sh_q[DATA_W-1:1]};
            end else begin
              frame_done = 1'b1;
              state_n    = RX_HUNT;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      div_q   <= '0;
      bit_q   <= '0;
      smp_q   <= '0;
      sh_q    <= '0;
      last_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      div_q   <= div_n;
      bit_q   <= bit_n;
      smp_q   <= smp_n;
      sh_q    <= sh_n;
      last_q  <= last_n;
    end
  end

  assign frame_stop = vote;
  assign frame_data = sh_q;
endmodule

// File: rtl/uart_duplex_port.sv
module uart_duplex_port
  import uart_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  logic              sync1_q, sync2_q;
  logic              rx_en_q, rx_en_n, filt_q, filt_n, half_q, half_n;
  logic              ri_q, ri_n, ti_q, ti_n, rb8_q, rb8_n;
  logic [DATA_W-1:0] rx_buf_q, rx_buf_n;
  logic              s16_tick, tx_roll, tx_done;
  logic              rx_done, rx_stop, accept, ctrl_wr, data_wr;
  logic [DATA_W-1:0] rx_data;

  uart_tick_gen #(.OVS(OVS)) i_tick (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .half_rate(half_q),
    .s16_tick(s16_tick), .tx_roll(tx_roll)
  );

  uart_tx_engine #(.DATA_W(DATA_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .load(data_wr), .load_data(reg_wdata),
    .roll(tx_roll), .txd(txd), .frame_done(tx_done)
  );

  uart_rx_engine #(.DATA_W(DATA_W), .OVS(OVS)) i_rx (
    .clk(clk), .rst_n(rst_n), .enable(rx_en_q), .s16_tick(s16_tick),
    .rxd_sync(sync2_q), .frame_done(rx_done), .frame_stop(rx_stop),
    .frame_data(rx_data)
  );

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
  assign accept  = rx_done && !ri_q && (!filt_q || rx_stop);

  always_comb begin
    rx_en_n  = rx_en_q;
    filt_n   = filt_q;
    half_n   = half_q;
    ri_n     = ri_q;
    ti_n     = ti_q;
    rb8_n    = rb8_q;
    rx_buf_n = rx_buf_q;
    if (ctrl_wr) begin
      rx_en_n = reg_wdata[CB_RX_EN];
      filt_n  = reg_wdata[CB_FILTER];
      half_n  = reg_wdata[CB_HALF];
      if (!reg_wdata[CB_RI]) ri_n = 1'b0;
      if (!reg_wdata[CB_TI]) ti_n = 1'b0;
    end
    if (accept) begin
      ri_n     = 1'b1;
      rb8_n    = rx_stop;
      rx_buf_n = rx_data;
    end
    if (tx_done) ti_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= 1'b1;
      sync2_q  <= 1'b1;
      rx_en_q  <= 1'b0;
      filt_q   <= 1'b0;
      half_q   <= 1'b0;
      ri_q     <= 1'b0;
      ti_q     <= 1'b0;
      rb8_q    <= 1'b0;
      rx_buf_q <= '0;
    end else begin
      sync1_q  <= rxd;
      sync2_q  <= sync1_q;
      rx_en_q  <= rx_en_n;
      filt_q   <= filt_n;
      half_q   <= half_n;
      ri_q     <= ri_n;
      ti_q     <= ti_n;
      rb8_q    <= rb8_n;
      rx_buf_q <= rx_buf_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_DATA) begin
      reg_rdata = rx_buf_q;
    end else begin
      reg_rdata[CB_RX_EN]  = rx_en_q;
      reg_rdata[CB_FILTER] = filt_q;
      reg_rdata[CB_HALF]   = half_q;
      reg_rdata[CB_STOP]   = rb8_q;
      reg_rdata[CB_RI]     = ri_q;
      reg_rdata[CB_TI]     = ti_q;
    end
  end

  assign irq = ri_q | ti_q;
endmodule

// File: rtl/uart_duplex_port_chk.sv
module uart_duplex_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              ri,
  input logic              ti,
  input logic [DATA_W-1:0] rx_buf,
  input logic              rx_en,
  input logic              txd,
  input logic              tx_roll
);
  logic clr_ri, clr_ti;
  assign clr_ri = reg_wr && reg_addr && !reg_wdata[4];
  assign clr_ti = reg_wr && reg_addr && !reg_wdata[5];

  a_r9_ri_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !clr_ri) |=> ri);

  a_r9_ti_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !clr_ti) |=> ti);

  a_r8_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ri |=> $stable(rx_buf));

  a_r5_no_rx_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(ri));

  a_r3_txd_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tx_roll));
endmodule

bind uart_duplex_port uart_duplex_port_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ri(ri_q), .ti(ti_q), .rx_buf(rx_buf_q),
  .rx_en(rx_en_q), .txd(txd), .tx_roll(tx_roll)
);

// File: tb/test_uart_duplex_port.sv
module test_uart_duplex_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rxd_drv = 1'b1;
  logic       loop_en = 1'b0;
  logic       rxd, txd, irq, baud_tick;
  logic [1:0] ph;
  int         bt_cnt;
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign rxd       = loop_en ? txd : rxd_drv;
  assign baud_tick = (ph == 2'd3);

  always @(posedge clk) begin
    if (!rst_n) begin
      ph     <= 2'd0;
      bt_cnt <= 0;
    end else begin
      ph <= ph + 2'd1;
      if (baud_tick) bt_cnt <= bt_cnt + 1;
    end
  end

  uart_duplex_port i_uart_duplex_port (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    while (ph == 2'd3) @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // control write keeping both flags: bits 4,5 written as 1
  task automatic set_ctrl(input bit en, input bit filt, input bit half);
    wr(1'b1, {2'b00, 1'b1, 1'b1, 1'b0, half, filt, en});
  endtask

  task automatic wait_until(input int tgt);
    while (bt_cnt < tgt) @(negedge clk);
  endtask

  task automatic wait_pulses(input int n);
    wait_until(bt_cnt + n);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stopb, input int glitch, input int dlen);
    logic [9:0] f;
    f = {stopb, d, 1'b0};
    wait_pulses(1);
    for (int k = 0; k < 10; k++) begin
      rxd_drv = f[k];
      if (k == glitch) begin
        wait_pulses(8); rxd_drv = ~f[k];
        wait_pulses(1); rxd_drv = f[k];
        wait_pulses(dlen - 9);
      end else begin
        wait_pulses(dlen);
      end
    end
    rxd_drv = 1'b1;
    wait_pulses(dlen);
  endtask

  task automatic tx_check(input logic [7:0] d, input int dlen);
    int c, st, bad;
    logic [9:0] f;
    logic [7:0] v;
    f = {1'b1, d, 1'b0};
    @(negedge clk);
    while (ph == 2'd3) @(negedge clk);
    c = bt_cnt;
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    check(txd === 1'b1, "R3 no change at write", txd, 1);
    st = (c / dlen + 1) * dlen;
    while (txd !== 1'b0) @(negedge clk);
    check(bt_cnt == st, "R3/R2 start boundary", bt_cnt, st);
    bad = 0;
    for (int k = 0; k < 9; k++) begin
      wait_until(st + k * dlen + dlen / 2);
      if (txd !== f[k]) bad++;
    end
    wait_until(st + 9 * dlen - 1);
    rd(1'b1, v);
    check(v[5] == 1'b0, "R4 TI still clear", v[5], 0);
    wait_until(st + 9 * dlen);
    rd(1'b1, v);
    check(v[5] == 1'b1, "R4 TI at tenth boundary", v[5], 1);
    wait_until(st + 9 * dlen + dlen / 2);
    if (txd !== f[9]) bad++;
    check(bad == 0, "R1 frame bits", bad, 0);
  endtask

  initial begin
    logic [7:0] v, b;
    int unsigned seed;
    seed = $urandom(32'd90125);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(txd === 1'b1, "R11 txd", txd, 1);
    check(irq === 1'b0, "R11 irq", irq, 0);
    rd(1'b1, v); check(v == 8'h00, "R11 ctrl", v, 0);
    rd(1'b0, v); check(v == 8'h00, "R11 data", v, 0);

    set_ctrl(1'b1, 1'b0, 1'b0);
    tx_check(8'hA5, 16);
    check(irq === 1'b1, "R10 irq from TI", irq, 1);
    wr(1'b1, 8'b0001_0001);  // R9 clear TI
    rd(1'b1, v); check(v[5] == 1'b0, "R9 TI cleared", v[5], 0);
    check(irq === 1'b0, "R10 irq low", irq, 0);
    wr(1'b1, 8'b0011_0001);  // R9 writing ones has no effect
    rd(1'b1, v); check(v[5:4] == 2'b00, "R9 ones ignored", v[5:4], 0);

    // receive directed
    send_frame(8'h3C, 1'b1, -1, 16);
    rd(1'b0, v); check(v == 8'h3C, "R8 data", v, 8'h3C);
    rd(1'b1, v); check(v[4:3] == 2'b11, "R8 RI and stop", v[4:3], 3);
    check(irq === 1'b1, "R10 irq from RI", irq, 1);
    send_frame(8'h81, 1'b1, -1, 16);
    rd(1'b0, v); check(v == 8'h3C, "R8 no overwrite while RI", v, 8'h3C);
    rd(1'b1, v); check(v[4] == 1'b1, "R9 RI kept by hardware", v[4], 1);
    wr(1'b1, 8'b0010_0011);
    send_frame(8'h55, 1'b0, -1, 16);
    rd(1'b1, v); check(v[4] == 1'b0, "R8 filter drops stop 0", v[4], 0);
    rd(1'b0, v); check(v == 8'h3C, "R8 filter keeps buffer", v, 8'h3C);
    send_frame(8'h66, 1'b1, -1, 16);
    rd(1'b0, v); check(v == 8'h66, "R8 filter passes stop 1", v, 8'h66);
    wr(1'b1, 8'b0010_0001);
    send_frame(8'h77, 1'b0, -1, 16);
    rd(1'b1, v); check(v[4:3] == 2'b10, "R8 stop 0 accepted unfiltered", v[4:3], 2);
    rd(1'b0, v); check(v == 8'h77, "R8 data stop 0", v, 8'h77);

    // R5 receive disabled
    wr(1'b1, 8'b0010_0000);
    send_frame(8'h12, 1'b1, -1, 16);
    rd(1'b1, v); check(v[4] == 1'b0, "R5 no RI when disabled", v[4], 0);
    rd(1'b0, v); check(v == 8'h77, "R5 buffer kept", v, 8'h77);
    wr(1'b1, 8'b0010_0001);

    // R6 single-tick glitches
    send_frame(8'hF0, 1'b1, 3, 16);
    rd(1'b0, v); check(v == 8'hF0, "R6 glitch on 0 bit", v, 8'hF0);
    wr(1'b1, 8'b0010_0001);
    send_frame(8'h0F, 1'b1, 2, 16);
    rd(1'b0, v); check(v == 8'h0F, "R6 glitch on 1 bit", v, 8'h0F);
    wr(1'b1, 8'b0010_0001);
    send_frame(8'hC3, 1'b1, 0, 16);
    rd(1'b0, v); check(v == 8'hC3, "R6 glitch in start bit", v, 8'hC3);
    wr(1'b1, 8'b0010_0001);

    // R7 false start
    wait_pulses(1);
    rxd_drv = 1'b0; wait_pulses(3); rxd_drv = 1'b1;
    wait_pulses(40);
    rd(1'b1, v); check(v[4] == 1'b0, "R7 false start dropped", v[4], 0);
    send_frame(8'h5A, 1'b1, -1, 16);
    rd(1'b0, v); check(v == 8'h5A, "R7 next frame received", v, 8'h5A);
    wr(1'b1, 8'b0000_0001);

    // random loopback
    loop_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      b = 8'($urandom);
      tx_check(b, 16);
      wait_pulses(16);
      rd(1'b0, v); check(v == b, "R1/R8 loopback data", v, b);
      rd(1'b1, v); check(v[5:3] == 3'b111, "R4/R8 loopback flags", v[5:3], 7);
      wr(1'b1, 8'b0000_0001);
    end
    loop_en = 1'b0;

    // R2 halved rate after fresh reset
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    set_ctrl(1'b1, 1'b0, 1'b1);
    tx_check(8'h96, 32);
    send_frame(8'h4B, 1'b1, -1, 32);
    rd(1'b0, v); check(v == 8'h4B, "R2 halved receive", v, 8'h4B);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule